// File: doc/BRIEF.md
# Cache Eviction Writeback Sequencer

This block runs the eviction of one line from a second-level cache when an incoming victim finds no free way. When the replace trigger is accepted, the block copies the line's data and dirty flag into its transaction buffer. The way is then considered free. The block sends a victim message toward the directory: a dirty victim for a modified or owned line, and a clean victim for an exclusive or shared line. It then waits for the memory writeback acknowledgement.

While it waits, probes and further victim requests can arrive. A downgrade probe is answered with data from the buffer. An invalidating probe moves the block to a cancel wait: there it only waits out the acknowledgement and refuses victims, so that a late acknowledgement cannot disturb a reused line. A victim request that arrives during a dirty eviction is acknowledged and its requester is recorded. The data or stale notice that this requester later sends is absorbed. If the memory acknowledgement arrives before that data, the block enters a drop state, throws the data away when it comes, and only then goes idle.

The replace trigger and the victim-message output are valid/ready streams. A transfer happens on a cycle where both valid and ready are high. A source holds valid and its payload until ready is seen, and the victim message keeps its payload stable while it is stalled. Victim requests are also handshaked. A request that sees vic_ready low has been recycled and must be presented again later. Acknowledgements, probes, returned data, unblocks and probe responses are single-cycle pulses.

Top module: `evict_wb_seq`

## Requirements
- R1: After reset seq_state is 0 (idle), repl_ready is 1, wait_src equals SELF_ID, and vmsg_valid, vack_valid, unblk_valid and prb_valid are all 0.
- R2: A replace accepted in idle with repl_line 0 (M) or 1 (O) sets seq_state to 1 (dirty wait) and raises vmsg_valid with vmsg_dirty=1 and vmsg_data equal to the captured repl_data; wait_src returns to SELF_ID.
- R3: A replace accepted in idle with repl_line 2 (E) or 3 (S) sets seq_state to 2 (clean wait) and raises vmsg_valid with vmsg_dirty=0 and the captured data.
- R4: While vmsg_valid is high and vmsg_ready is low, vmsg_valid, vmsg_dirty and vmsg_data hold their values; the message clears one cycle after ready is seen.
- R5: ack_valid in state 1 or 2 returns seq_state to 0, and repl_ready is 1 again.
- R6: repl_ready is 0 in every state other than idle, so a replace trigger there is recycled and leaves the state unchanged.
- R7: A probe with probe_kind 0 (invalidate) or 1 (invalidate with data) in state 1 or 2 moves to state 3 (cancel wait). In state 3 vic_ready is 0, every event except ack_valid is ignored, and ack_valid moves to state 0.
- R8: A probe with probe_kind 2 (downgrade) in state 1 or 2 pulses prb_valid one cycle later, with prb_data and prb_dirty taken from the buffer, and leaves the state unchanged.
- R9: In state 1 vic_ready is 1. An accepted victim request pulses vack_valid one cycle later with vack_dst equal to vic_src, sets wait_src to vic_src, and moves to state 4 (forward wait).
- R10: wbd_valid in state 4 pulses unblk_valid one cycle later, sets wait_src back to SELF_ID and returns to state 1.
- R11: ack_valid in state 4 moves to state 5 (drop). wbd_valid in state 5 pulses unblk_valid and returns to state 0.
- R12: Events not listed for a state (for example wbd_valid in state 1, or a downgrade in state 3) change neither the state nor any output. When several events arrive in one cycle, the acknowledgement takes precedence, then the probe, then the victim request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| repl_valid | input | 1 | Replace trigger valid |
| repl_ready | output | 1 | Replace trigger accepted (idle only) |
| repl_line | input | 2 | State of the line being replaced: 0 M, 1 O, 2 E, 3 S |
| repl_data | input | DW | Data of the line being replaced |
| ack_valid | input | 1 | Memory writeback acknowledgement pulse |
| probe_valid | input | 1 | Probe pulse |
| probe_kind | input | 2 | 0 invalidate, 1 invalidate with data, 2 downgrade |
| vic_valid | input | 1 | Victim request valid |
| vic_ready | output | 1 | Victim request accepted |
| vic_src | input | SW | Requester of the victim request |
| wbd_valid | input | 1 | Returned victim data or stale notice pulse |
| vmsg_valid | output | 1 | Victim message valid |
| vmsg_ready | input | 1 | Victim message accepted by the directory |
| vmsg_dirty | output | 1 | Victim message is dirty |
| vmsg_data | output | DW | Victim message data |
| vack_valid | output | 1 | Acknowledgement pulse to a victim requester |
| vack_dst | output | SW | Destination of the acknowledgement |
| unblk_valid | output | 1 | Not-valid unblock pulse |
| prb_valid | output | 1 | Downgrade probe response pulse |
| prb_dirty | output | 1 | Dirty flag of the probe response |
| prb_data | output | DW | Data of the probe response |
| wait_src | output | SW | Source currently expected to send writeback data |
| seq_state | output | 3 | Sequencer state code |

## Verification
Every result is registered, so each one is due exactly one clock after the edge that samples its stimulus. This applies to the state code, the victim message, the requester acknowledgement, the unblock and the probe response. The bench applies each stimulus at a falling edge and samples every output at the following falling edge, one full cycle later, against a model of the requirements. The back-pressure case holds vmsg_ready low for several falling edges and checks on each of them that the payload is unchanged.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_DIRTY  = 3'd1,
    SQ_CLEAN  = 3'd2,
    SQ_CANCEL = 3'd3,
    SQ_FWD    = 3'd4,
    SQ_DROP   = 3'd5
  } seq_st_t;

  localparam logic [1:0] LN_M = 2'd0;
  localparam logic [1:0] LN_O = 2'd1;

  localparam logic [1:0] PK_INV  = 2'd0;
  localparam logic [1:0] PK_INVD = 2'd1;
  localparam logic [1:0] PK_DOWN = 2'd2;
endpackage

// File: rtl/evq_buf.sv
module evq_buf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_dirty,
  input  logic          out_ready,
  input  logic          prb_fire,
  output logic          vmsg_valid,
  output logic          vmsg_dirty,
  output logic [DW-1:0] vmsg_data,
  output logic          prb_valid,
  output logic          prb_dirty,
  output logic [DW-1:0] prb_data
);
  logic [DW-1:0] buf_data;
  logic          buf_dirty;

  // transaction buffer: captured once per eviction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_data  <= '0;
      buf_dirty <= 1'b0;
    end else if (load) begin
      buf_data  <= load_data;
      buf_dirty <= load_dirty;
    end
  end

  // outgoing victim message, held until the directory takes it
  always_ff @(posedge clk) begin
    if (!rst_n)                   vmsg_valid <= 1'b0;
    else if (load)                vmsg_valid <= 1'b1;
    else if (vmsg_valid && out_ready) vmsg_valid <= 1'b0;
  end

  assign vmsg_data  = buf_data;
  assign vmsg_dirty = buf_dirty;

  // downgrade probe response from the buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prb_valid <= 1'b0;
      prb_dirty <= 1'b0;
      prb_data  <= '0;
    end else begin
      prb_valid <= prb_fire;
      if (prb_fire) begin
        prb_dirty <= buf_dirty;
        prb_data  <= buf_data;
      end
    end
  end

  p_vmsg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vmsg_valid && !out_ready) |=> (vmsg_valid && $stable(vmsg_data) && $stable(vmsg_dirty)));
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl
  import evq_pkg::*;
#(
  parameter int SW = 4,
  parameter logic [SW-1:0] SELF_ID = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          repl_fire,
  input  logic [1:0]    repl_line,
  input  logic          ack_valid,
  input  logic          probe_valid,
  input  logic [1:0]    probe_kind,
  input  logic          vic_valid,
  input  logic [SW-1:0] vic_src,
  input  logic          wbd_valid,
  output seq_st_t       st,
  output logic          vic_ready,
  output logic          vack_valid,
  output logic [SW-1:0] vack_dst,
  output logic          unblk_valid,
  output logic          prb_fire,
  output logic [SW-1:0] wait_src
);
  seq_st_t       st_n;
  logic [SW-1:0] src_n;
  logic          vack_n, unb_n;
  logic          inv_probe;

  assign inv_probe = probe_valid && (probe_kind == PK_INV || probe_kind == PK_INVD);
  assign vic_ready = (st == SQ_DIRTY) && !ack_valid && !probe_valid;

  always_comb begin
    st_n     = st;
    src_n    = wait_src;
    vack_n   = 1'b0;
    unb_n    = 1'b0;
    prb_fire = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        if (repl_fire) begin
          st_n  = (repl_line == LN_M || repl_line == LN_O) ? SQ_DIRTY : SQ_CLEAN;
          src_n = SELF_ID;
        end
      end
      SQ_DIRTY, SQ_CLEAN: begin
        if (ack_valid)                                   st_n = SQ_IDLE;
        else if (inv_probe)                              st_n = SQ_CANCEL;
        else if (probe_valid && probe_kind == PK_DOWN)   prb_fire = 1'b1;
        else if (vic_valid && vic_ready) begin
          vack_n = 1'b1;
          src_n  = vic_src;
          st_n   = SQ_FWD;
        end
      end
      SQ_CANCEL: if (ack_valid) st_n = SQ_IDLE;
      SQ_FWD: begin
        if (ack_valid) st_n = SQ_DROP;
        else if (wbd_valid) begin
          unb_n = 1'b1;
          src_n = SELF_ID;
          st_n  = SQ_DIRTY;
        end
      end
      SQ_DROP: begin
        if (wbd_valid) begin
          unb_n = 1'b1;
          st_n  = SQ_IDLE;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= SQ_IDLE;
      wait_src    <= SELF_ID;
      vack_valid  <= 1'b0;
      vack_dst    <= '0;
      unblk_valid <= 1'b0;
    end else begin
      st          <= st_n;
      wait_src    <= src_n;
      vack_valid  <= vack_n;
      unblk_valid <= unb_n;
      if (vack_n) vack_dst <= vic_src;
    end
  end

  p_cancel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_CANCEL && !ack_valid) |=> (st == SQ_CANCEL));
  p_vack_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vack_valid |-> (st == SQ_FWD || st == SQ_DROP || st == SQ_DIRTY));
  p_unblk_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unblk_valid) |-> ($past(st) == SQ_FWD || $past(st) == SQ_DROP));
  p_cancel_noacc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_CANCEL) |-> !vic_ready);
endmodule

// File: rtl/evict_wb_seq.sv
module evict_wb_seq
  import evq_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 4,
  parameter logic [SW-1:0] SELF_ID = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          repl_valid,
  output logic          repl_ready,
  input  logic [1:0]    repl_line,
  input  logic [DW-1:0] repl_data,
  input  logic          ack_valid,
  input  logic          probe_valid,
  input  logic [1:0]    probe_kind,
  input  logic          vic_valid,
  output logic          vic_ready,
  input  logic [SW-1:0] vic_src,
  input  logic          wbd_valid,
  output logic          vmsg_valid,
  input  logic          vmsg_ready,
  output logic          vmsg_dirty,
  output logic [DW-1:0] vmsg_data,
  output logic          vack_valid,
  output logic [SW-1:0] vack_dst,
  output logic          unblk_valid,
  output logic          prb_valid,
  output logic          prb_dirty,
  output logic [DW-1:0] prb_data,
  output logic [SW-1:0] wait_src,
  output logic [2:0]    seq_state
);
  seq_st_t st;
  logic    repl_fire, prb_fire, line_dirty;

  assign repl_ready = (st == SQ_IDLE) && !vmsg_valid;
  assign repl_fire  = repl_valid && repl_ready;
  assign line_dirty = (repl_line == LN_M) || (repl_line == LN_O);
  assign seq_state  = st;

  evq_ctrl #(.SW(SW), .SELF_ID(SELF_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .repl_fire(repl_fire), .repl_line(repl_line),
    .ack_valid(ack_valid), .probe_valid(probe_valid), .probe_kind(probe_kind),
    .vic_valid(vic_valid), .vic_src(vic_src), .wbd_valid(wbd_valid),
    .st(st), .vic_ready(vic_ready), .vack_valid(vack_valid), .vack_dst(vack_dst),
    .unblk_valid(unblk_valid), .prb_fire(prb_fire), .wait_src(wait_src)
  );

  evq_buf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(repl_fire), .load_data(repl_data),
    .load_dirty(line_dirty), .out_ready(vmsg_ready), .prb_fire(prb_fire),
    .vmsg_valid(vmsg_valid), .vmsg_dirty(vmsg_dirty), .vmsg_data(vmsg_data),
    .prb_valid(prb_valid), .prb_dirty(prb_dirty), .prb_data(prb_data)
  );

  p_prb_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    prb_valid |-> (st == SQ_DIRTY || st == SQ_CLEAN));
  p_busy_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st != SQ_IDLE && repl_valid) |=> (st != SQ_IDLE || $past(ack_valid) || $past(wbd_valid)));
endmodule

// File: tb/evict_wb_seq_tb_top.sv
`timescale 1ns/1ps
module evict_wb_seq_tb_top;
  localparam int DW = 32;
  localparam int SW = 4;
  localparam logic [SW-1:0] SELF = 4'd0;

  logic clk = 1'b0;
  logic rst_n;
  logic repl_valid, repl_ready, ack_valid, probe_valid, vic_valid, vic_ready, wbd_valid;
  logic [1:0] repl_line, probe_kind;
  logic [DW-1:0] repl_data, vmsg_data, prb_data;
  logic [SW-1:0] vic_src, vack_dst, wait_src;
  logic vmsg_valid, vmsg_ready, vmsg_dirty, vack_valid, unblk_valid, prb_valid, prb_dirty;
  logic [2:0] seq_state;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  evict_wb_seq #(.DW(DW), .SW(SW), .SELF_ID(SELF)) dut_i (.*);

  // reference model state
  int m_st;
  logic m_dirty;
  logic [DW-1:0] m_data;
  logic [SW-1:0] m_src;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    repl_valid = 0; ack_valid = 0; probe_valid = 0; vic_valid = 0; wbd_valid = 0;
  endtask

  // ev: 0 replace, 1 ack, 2 inv, 3 inv-data, 4 downgrade, 5 victim, 6 data
  task automatic do_ev(int ev, logic [1:0] ln, logic [DW-1:0] d, logic [SW-1:0] s, string req);
    bit e_vm, e_vack, e_unb, e_prb;
    @(negedge clk);
    idle_in();
    repl_line = ln; repl_data = d; vic_src = s;
    case (ev)
      0: repl_valid = 1;
      1: ack_valid = 1;
      2: begin probe_valid = 1; probe_kind = 2'd0; end
      3: begin probe_valid = 1; probe_kind = 2'd1; end
      4: begin probe_valid = 1; probe_kind = 2'd2; end
      5: vic_valid = 1;
      default: wbd_valid = 1;
    endcase
    #0.5;
    chk({req, " repl_ready"}, repl_ready, (m_st == 0));
    chk({req, " vic_ready"}, vic_ready, (m_st == 1 && ev == 5) ? 1 : (m_st == 1 ? (ev != 1 && ev != 2 && ev != 3 && ev != 4) : 0));
    e_vm = 0; e_vack = 0; e_unb = 0; e_prb = 0;
    case (m_st)
      0: if (ev == 0) begin m_st = (ln < 2) ? 1 : 2; m_dirty = (ln < 2); m_data = d; m_src = SELF; e_vm = 1; end
      1, 2: begin
        if (ev == 1) m_st = 0;
        else if (ev == 2 || ev == 3) m_st = 3;
        else if (ev == 4) e_prb = 1;
        else if (ev == 5 && m_st == 1) begin e_vack = 1; m_src = s; m_st = 4; end
      end
      3: if (ev == 1) m_st = 0;
      4: if (ev == 1) m_st = 5; else if (ev == 6) begin e_unb = 1; m_src = SELF; m_st = 1; end
      default: if (ev == 6) begin e_unb = 1; m_st = 0; end
    endcase
    @(negedge clk);
    idle_in();
    chk({req, " state"}, seq_state, m_st);
    chk({req, " vmsg_valid"}, vmsg_valid, e_vm);
    if (e_vm) begin
      chk({req, " vmsg_dirty"}, vmsg_dirty, m_dirty);
      chk({req, " vmsg_data"}, vmsg_data, m_data);
    end
    chk({req, " vack"}, vack_valid, e_vack);
    if (e_vack) chk({req, " vack_dst"}, vack_dst, s);
    chk({req, " unblk"}, unblk_valid, e_unb);
    chk({req, " prb"}, prb_valid, e_prb);
    if (e_prb) begin
      chk({req, " prb_data"}, prb_data, m_data);
      chk({req, " prb_dirty"}, prb_dirty, m_dirty);
    end
    chk({req, " wait_src"}, wait_src, m_src);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    idle_in();
    repl_line = 0; repl_data = 0; probe_kind = 0; vic_src = 0; vmsg_ready = 1;
    rst_n = 0;
    m_st = 0; m_dirty = 0; m_data = 0; m_src = SELF;
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 repl_ready", repl_ready, 1);
    chk("R1 outputs", {vmsg_valid, vack_valid, unblk_valid, prb_valid}, 0);
    chk("R1 wait_src", wait_src, SELF);

    // R2 dirty eviction, R8 downgrade, R5 ack
    do_ev(0, 2'd0, 32'hA5A5_0001, 0, "R2");
    do_ev(4, 0, 0, 0, "R8");
    do_ev(0, 2'd3, 32'h1234, 0, "R6");
    do_ev(1, 0, 0, 0, "R5");
    // R3 clean eviction, R12 ignored data, R7 cancel path
    do_ev(0, 2'd2, 32'hBEEF_0002, 0, "R3");
    do_ev(6, 0, 0, 0, "R12");
    do_ev(5, 0, 0, 4'd3, "R12 victim in clean");
    do_ev(3, 0, 0, 0, "R7");
    do_ev(4, 0, 0, 0, "R7 downgrade ignored");
    do_ev(5, 0, 0, 4'd5, "R7 victim recycled");
    do_ev(1, 0, 0, 0, "R7 ack");
    // R9/R10 forward path, then R11 drop path
    do_ev(0, 2'd1, 32'h0000_C0DE, 0, "R2 owned");
    do_ev(5, 0, 0, 4'd9, "R9");
    do_ev(6, 0, 0, 0, "R10");
    do_ev(5, 0, 0, 4'd6, "R9 again");
    do_ev(1, 0, 0, 0, "R11 ack");
    do_ev(2, 0, 0, 0, "R12 probe in drop");
    do_ev(6, 0, 0, 0, "R11 drop");

    // R4 back-pressure on the victim message
    vmsg_ready = 0;
    @(negedge clk);
    repl_valid = 1; repl_line = 2'd1; repl_data = 32'hFACE_0004;
    @(negedge clk);
    repl_valid = 0;
    for (int k = 0; k < 4; k++) begin
      chk("R4 valid held", vmsg_valid, 1);
      chk("R4 data held", vmsg_data, 32'hFACE_0004);
      chk("R4 dirty held", vmsg_dirty, 1);
      @(negedge clk);
    end
    vmsg_ready = 1;
    @(negedge clk);
    chk("R4 cleared", vmsg_valid, 0);
    m_st = 1; m_dirty = 1; m_data = 32'hFACE_0004; m_src = SELF;
    do_ev(1, 0, 0, 0, "R5 after stall");

    // random mix against the model
    for (int i = 0; i < 400; i++) begin
      int ev;
      ev = $urandom_range(0, 6);
      do_ev(ev, 2'($urandom_range(0, 3)), $urandom, 4'($urandom_range(1, 15)), "R12 random");
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule